// File: doc/BRIEF.md
# Cellular Neural Network Grid with Time-Slot Multipliers

This block is a small cellular neural network. A rectangular grid of cells holds signed 5-bit values. Each cell is wired to itself and to its eight nearest neighbours. One bank of nine signed weights is shared by every cell. On each iteration every cell forms a weighted sum of its 3×3 neighbourhood, limits that sum to the value range, and stores the result as its new value. All cells update together. Suitable weight sets give simple image operations such as edge finding, gap filling or noise cleaning.

The block uses no parallel multipliers. An iteration is split into fifteen time slots. A neighbour value becomes a pulse that is high for as many slots as its magnitude. A weight becomes a fixed pattern of slots spread evenly over the window. The two are ANDed together, and an up/down counter in each cell counts the slots where both are high, adding or subtracting according to the XOR of the two signs. As a result each product is rounded to the nearest fifteenth. One iteration of the whole grid takes fifteen clocks, whatever its size.

The user writes the weights while the block is idle, loads an image as a single parallel word, then issues a start with an iteration count. The block raises busy while it works, pulses done when it finishes, and shows every cell's value on a flat output bus at all times.

Top module: `cnn_array`

## Requirements
- R1: After reset every cell value is zero, all nine weights are zero, and busy and done are low.
- R2: A weight write (wt_we) stores a magnitude and a sign into slot wt_idx only while the block is idle. Slot k = 3*(dr+1)+(dc+1) scales the neighbour at row offset dr and column offset dc, with dr = -1 the row above and dc = -1 the column to the left, so slot 4 is the cell itself. Writes with wt_idx above 8, and writes while busy, change nothing.
- R3: A load_req in idle takes one busy cycle, after which every cell holds its field of img_in. Cell (r,c) uses bits [(r*COLS+c)*5 +: 5], where bit 4 is the sign (1 = negative) and bits 3:0 are the magnitude. If load_req and start arrive together, the load wins.
- R4: A start in idle with iter_cnt = N > 0 keeps busy high for exactly 15*N cycles. Done then goes high for exactly one cycle and the block returns to idle.
- R5: A start with iter_cnt = 0 raises done in the next cycle with no busy cycle, and the cell values stay unchanged.
- R6: Each neighbour-by-weight product is floor((|x|*|w|+7)/15) counts, negative when exactly one of the two signs is negative.
- R7: Any neighbour position that falls outside the grid contributes zero.
- R8: A new cell value is the sum of its nine products, limited to the range -15..+15. A result of zero is stored with sign bit 0.
- R9: All cells change together at the end of each 15-slot window, and every cell uses the values from the previous iteration.
- R10: A start or load_req that arrives while busy has no effect: it neither lengthens the run nor changes the cell values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_we | input | 1 | Weight write strobe |
| wt_idx | input | 4 | Weight slot, 0..8 |
| wt_mag | input | 4 | Weight magnitude, in fifteenths |
| wt_neg | input | 1 | Weight sign, 1 = negative |
| load_req | input | 1 | Load img_in into the grid |
| img_in | input | ROWS*COLS*5 | Parallel image, 5 bits per cell |
| start | input | 1 | Begin iterating |
| iter_cnt | input | ITER_W | Number of iterations to run |
| busy | output | 1 | High during load and while iterating |
| done | output | 1 | One-cycle pulse at the end of a run |
| cell_out | output | ROWS*COLS*5 | Current value of every cell, same layout as img_in |

## Verification
The main function is tried with several weight sets, each chosen to expose a different kind of fault. A centre-only unity weight must return the image unchanged, which shows whether the rounding and the sign handling are exact. A single off-centre weight shifts the image by one row per iteration, so the result reveals a wrong neighbour order, boundary cells that are not zero, and cells that read partly updated values. An irregular signed weight set, run for several iterations while start, load and weight writes are pulsed in the middle of the run, is compared against an independent integer model. A saturating set and a cancelling left/right set check the upper and lower limits and the sign of a zero result.

// File: rtl/cnn_pkg.sv
package cnn_pkg;
    localparam int MAG_W  = 4;
    localparam int SLOTS  = (1 << MAG_W) - 1;
    localparam int SLOT_W = MAG_W;
    localparam int NBR    = 9;
    localparam int IDX_W  = $clog2(NBR + 1);
    localparam int CVAL_W = MAG_W + 1;
    localparam int ACC_W  = $clog2(NBR * SLOTS + 1) + 1;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } cval_t;

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_DONE} ctl_state_e;

    // Weight slot pattern: spread |w| hits evenly across the window so that the
    // number of hits in slots 1..x equals round(x*|w|/SLOTS).
    function automatic logic slot_hit(input logic [MAG_W-1:0] wmag,
                                      input logic [SLOT_W-1:0] slot);
        int hi;
        int lo;
        hi = (int'(slot) * int'(wmag) + SLOTS / 2) / SLOTS;
        lo = ((int'(slot) - 1) * int'(wmag) + SLOTS / 2) / SLOTS;
        return hi != lo;
    endfunction
endpackage

// File: rtl/cnn_ctrl.sv
module cnn_ctrl
    import cnn_pkg::*;
#(
    parameter int ITER_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ITER_W-1:0] iter_cnt,
    input  logic              load_req,
    output logic              busy,
    output logic              done,
    output logic              idle,
    output logic              load_now,
    output logic              run,
    output logic [SLOT_W-1:0] slot,
    output logic              slot_first,
    output logic              slot_last
);
    localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(SLOTS);
    localparam logic [SLOT_W-1:0] FIRST_SLOT = SLOT_W'(1);

    typedef struct packed {
        ctl_state_e        st;
        logic [SLOT_W-1:0] slot;
        logic [ITER_W-1:0] iter;
        logic [ITER_W-1:0] tgt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (load_req) begin
                    ctl_d.st = ST_LOAD;
                end else if (start) begin
                    ctl_d.tgt  = iter_cnt;
                    ctl_d.iter = '0;
                    ctl_d.slot = FIRST_SLOT;
                    ctl_d.st   = (iter_cnt == '0) ? ST_DONE : ST_RUN;
                end
            end
            ST_LOAD: ctl_d.st = ST_IDLE;
            ST_RUN: begin
                if (ctl_q.slot == LAST_SLOT) begin
                    ctl_d.slot = FIRST_SLOT;
                    ctl_d.iter = ctl_q.iter + ITER_W'(1);
                    if ((ctl_q.iter + ITER_W'(1)) == ctl_q.tgt) ctl_d.st = ST_DONE;
                end else begin
                    ctl_d.slot = ctl_q.slot + SLOT_W'(1);
                end
            end
            ST_DONE: ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, slot: FIRST_SLOT, iter: '0, tgt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign idle       = (ctl_q.st == ST_IDLE);
    assign load_now   = (ctl_q.st == ST_LOAD);
    assign run        = (ctl_q.st == ST_RUN);
    assign busy       = load_now | run;
    assign done       = (ctl_q.st == ST_DONE);
    assign slot       = ctl_q.slot;
    assign slot_first = run && (ctl_q.slot == FIRST_SLOT);
    assign slot_last  = run && (ctl_q.slot == LAST_SLOT);

    // R4: done is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4: the slot counter stays inside the window while running
    p_slot_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (slot >= FIRST_SLOT && slot <= LAST_SLOT));
    // R4: a nonzero start makes the block busy in the next cycle
    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && !load_req && iter_cnt != '0) |=> (run && slot == FIRST_SLOT));
    // R5: a zero count finishes at once
    p_zero_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && !load_req && iter_cnt == '0) |=> done);
    // R10: a start while running does not restart the window
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !slot_last) |=> (run && slot == $past(slot) + SLOT_W'(1)));
endmodule

// File: rtl/cnn_wbank.sv
module cnn_wbank
    import cnn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [MAG_W-1:0]  mag,
    input  logic              neg,
    input  logic [SLOT_W-1:0] slot,
    output logic [NBR-1:0]    wgate,
    output logic [NBR-1:0]    wneg
);
    typedef struct packed {
        cval_t [NBR-1:0] w;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_ok && we && (idx < IDX_W'(NBR))) begin
            bank_d.w[idx] = '{neg: neg, mag: mag};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    for (genvar k = 0; k < NBR; k++) begin : g_gate
        assign wgate[k] = slot_hit(bank_q.w[k].mag, slot);
        assign wneg[k]  = bank_q.w[k].neg;
    end

    // R2: the weights cannot change while the block is not idle
    p_wt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(bank_q));
endmodule

// File: rtl/cnn_cell.sv
module cnn_cell
    import cnn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cval_t [NBR-1:0]   nbr,
    input  logic  [NBR-1:0]   wgate,
    input  logic  [NBR-1:0]   wneg,
    input  logic [SLOT_W-1:0] slot,
    input  logic              run,
    input  logic              slot_first,
    input  logic              slot_last,
    input  logic              load_now,
    input  cval_t             load_val,
    output cval_t             value
);
    localparam logic signed [ACC_W-1:0] LIM = ACC_W'(SLOTS);

    typedef struct packed {
        cval_t                   st;
        logic signed [ACC_W-1:0] acc;
    } cell_t;

    cell_t cell_d, cell_q;
    logic signed [ACC_W-1:0] delta, total, mag_abs;

    always_comb begin
        delta = '0;
        for (int k = 0; k < NBR; k++) begin
            if ((slot <= nbr[k].mag) && wgate[k]) begin
                if (nbr[k].neg ^ wneg[k]) delta = delta - ACC_W'(1);
                else                      delta = delta + ACC_W'(1);
            end
        end
        total   = (slot_first ? '0 : cell_q.acc) + delta;
        mag_abs = total[ACC_W-1] ? -total : total;

        cell_d = cell_q;
        if (load_now) begin
            cell_d.st = load_val;
        end else if (run) begin
            cell_d.acc = total;
            if (slot_last) begin
                cell_d.acc = '0;
                if (total > LIM)       cell_d.st = '{neg: 1'b0, mag: MAG_W'(SLOTS)};
                else if (total < -LIM) cell_d.st = '{neg: 1'b1, mag: MAG_W'(SLOTS)};
                else                   cell_d.st = '{neg: total[ACC_W-1], mag: mag_abs[MAG_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    assign value = cell_q.st;

    // R9: a cell value only moves at the close of a window
    p_hold_mid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !slot_last) |=> $stable(value));
    // R8: a computed result never carries a negative zero
    p_zero_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && slot_last) |=> !(value.neg && value.mag == '0));
endmodule

// File: rtl/cnn_array.sv
module cnn_array
    import cnn_pkg::*;
#(
    parameter int ROWS   = 20,
    parameter int COLS   = 20,
    parameter int ITER_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wt_we,
    input  logic [3:0]                    wt_idx,
    input  logic [3:0]                    wt_mag,
    input  logic                          wt_neg,
    input  logic                          load_req,
    input  logic [ROWS*COLS*5-1:0]        img_in,
    input  logic                          start,
    input  logic [ITER_W-1:0]             iter_cnt,
    output logic                          busy,
    output logic                          done,
    output logic [ROWS*COLS*5-1:0]        cell_out
);
    localparam int NCELL = ROWS * COLS;

    logic              idle, load_now, run, slot_first, slot_last;
    logic [SLOT_W-1:0] slot;
    logic [NBR-1:0]    wgate, wneg;
    cval_t             cell_v [NCELL];

    cnn_ctrl #(.ITER_W(ITER_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .iter_cnt(iter_cnt),
        .load_req(load_req), .busy(busy), .done(done), .idle(idle),
        .load_now(load_now), .run(run), .slot(slot),
        .slot_first(slot_first), .slot_last(slot_last)
    );

    cnn_wbank u_wbank (
        .clk(clk), .rst_n(rst_n), .wr_ok(idle), .we(wt_we),
        .idx(IDX_W'(wt_idx)), .mag(wt_mag), .neg(wt_neg), .slot(slot),
        .wgate(wgate), .wneg(wneg)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            cval_t [NBR-1:0] nbr;
            for (genvar k = 0; k < NBR; k++) begin : g_nbr
                localparam int RR = r + k / 3 - 1;
                localparam int CC = c + k % 3 - 1;
                if (RR >= 0 && RR < ROWS && CC >= 0 && CC < COLS) begin : g_in
                    assign nbr[k] = cell_v[RR * COLS + CC];
                end else begin : g_edge
                    assign nbr[k] = '0;
                end
            end
            cnn_cell u_cell (
                .clk(clk), .rst_n(rst_n), .nbr(nbr), .wgate(wgate), .wneg(wneg),
                .slot(slot), .run(run), .slot_first(slot_first),
                .slot_last(slot_last), .load_now(load_now),
                .load_val(img_in[(r*COLS+c)*CVAL_W +: CVAL_W]),
                .value(cell_v[r*COLS+c])
            );
            assign cell_out[(r*COLS+c)*CVAL_W +: CVAL_W] = cell_v[r*COLS+c];
        end
    end

    // R3: a load cycle copies the image into the grid
    p_load_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_now |=> (cell_out == $past(img_in)));
    // R10: a load request during a run leaves the grid untouched outside window ends
    p_no_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !slot_last && load_req) |=> $stable(cell_out));
endmodule

// File: tb/cnn_array_tb_top.sv
`timescale 1ns/1ps
module cnn_array_tb_top;
    import cnn_pkg::*;
    localparam int ROWS = 4;
    localparam int COLS = 5;
    localparam int NC   = ROWS * COLS;
    localparam int VW   = NC * 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wt_we = 1'b0, wt_neg = 1'b0, load_req = 1'b0, start = 1'b0;
    logic [3:0]    wt_idx = '0, wt_mag = '0;
    logic [VW-1:0] img_in = '0;
    logic [7:0]    iter_cnt = '0;
    logic          busy, done;
    logic [VW-1:0] cell_out;

    always #2.5 clk = ~clk;

    cnn_array #(.ROWS(ROWS), .COLS(COLS), .ITER_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_idx(wt_idx), .wt_mag(wt_mag),
        .wt_neg(wt_neg), .load_req(load_req), .img_in(img_in), .start(start),
        .iter_cnt(iter_cnt), .busy(busy), .done(done), .cell_out(cell_out)
    );

    int total = 0;
    int bad   = 0;
    int mv [NC];
    int wv [NBR];
    logic [VW-1:0] expq [$];
    string         tagq [$];

    task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic logic [VW-1:0] pack_model();
        logic [VW-1:0] p;
        p = '0;
        for (int i = 0; i < NC; i++) p[i*5 +: 5] = {mv[i] < 0, 4'(iabs(mv[i]))};
        return p;
    endfunction

    function automatic void model_step();
        int nx [NC];
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                int s;
                s = 0;
                for (int k = 0; k < NBR; k++) begin
                    int rr, cc, x, p;
                    rr = r + k / 3 - 1;
                    cc = c + k % 3 - 1;
                    x  = (rr >= 0 && rr < ROWS && cc >= 0 && cc < COLS) ? mv[rr*COLS+cc] : 0;
                    p  = (iabs(x) * iabs(wv[k]) + 7) / 15;
                    if ((x < 0) != (wv[k] < 0)) s -= p;
                    else                        s += p;
                end
                if (s > 15)  s = 15;
                if (s < -15) s = -15;
                nx[r*COLS+c] = s;
            end
        end
        for (int i = 0; i < NC; i++) mv[i] = nx[i];
    endfunction

    // Scoreboard monitor: every done pulse must match the next expected image.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (expq.size() == 0) begin
                chk("R4 unexpected done", 1, 0);
            end else begin
                chk(tagq.pop_front(), cell_out, expq.pop_front());
            end
        end
    end

    task automatic set_w(input int k, input int v);
        @(negedge clk);
        wt_we  = 1'b1;
        wt_idx = 4'(k);
        wt_mag = 4'(iabs(v));
        wt_neg = (v < 0);
        @(negedge clk);
        wt_we = 1'b0;
        if (k < NBR) wv[k] = v;
    endtask

    task automatic load_model();
        img_in = pack_model();
        @(negedge clk);
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        chk("R3 busy during load", VW'(busy), VW'(1));
        @(negedge clk);
        chk("R3 image captured", cell_out, img_in);
        chk("R3 idle after load", VW'(busy), VW'(0));
    endtask

    task automatic run(input int n, input string tag, input bit disturb);
        int cycles;
        logic [VW-1:0] keep_img;
        for (int i = 0; i < n; i++) model_step();
        expq.push_back(pack_model());
        tagq.push_back(tag);
        keep_img = img_in;
        @(negedge clk);
        start    = 1'b1;
        iter_cnt = 8'(n);
        @(negedge clk);
        start  = 1'b0;
        cycles = 0;
        while (busy) begin
            cycles++;
            if (disturb && cycles == 5) begin
                start = 1'b1; iter_cnt = 8'd1; load_req = 1'b1;
                img_in = {NC{5'b01001}};
                wt_we = 1'b1; wt_idx = 4'd4; wt_mag = 4'd15; wt_neg = 1'b1;
            end
            if (disturb && cycles == 6) begin
                start = 1'b0; load_req = 1'b0; wt_we = 1'b0;
            end
            @(negedge clk);
        end
        img_in = keep_img;
        chk({tag, " R4 busy length"}, VW'(cycles), VW'(15 * n));
        chk({tag, " R4 done raised"}, VW'(done), VW'(1));
        @(negedge clk);
        chk({tag, " R4 done single"}, VW'(done), VW'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < NBR; k++) wv[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cells zero", cell_out, '0);
        chk("R1 busy low", VW'(busy), VW'(0));
        chk("R1 done low", VW'(done), VW'(0));

        for (int i = 0; i < NC; i++) mv[i] = ((i * 7 + (i / COLS) * 3) % 31) - 15;
        for (int i = 0; i < NC; i++) if (mv[i] == 0) mv[i] = 4;
        load_model();
        run(0, "R5 zero count keeps image", 0);
        run(1, "R1 reset weights give zero", 0);

        for (int i = 0; i < NC; i++) mv[i] = ((i * 11) % 29) - 14;
        for (int i = 0; i < NC; i++) if (mv[i] == 0) mv[i] = -3;
        load_model();
        set_w(4, 15);
        run(2, "R6 unity centre identity", 0);

        set_w(4, 0);
        set_w(1, 15);
        run(2, "R7 R9 R2 shift down with zero edge", 0);

        set_w(0, 3); set_w(1, -7); set_w(2, 11); set_w(3, -2); set_w(4, 9);
        set_w(5, 5); set_w(6, -13); set_w(7, 1); set_w(8, 8);
        for (int i = 0; i < NC; i++) mv[i] = ((i * 13) % 31) - 15;
        load_model();
        run(3, "R6 R10 R2 mixed weights with busy stimulus", 1);

        set_w(9, 15);
        set_w(12, -15);
        run(1, "R2 out of range index ignored", 0);

        for (int i = 0; i < NC; i++) mv[i] = 15;
        load_model();
        for (int k = 0; k < NBR; k++) set_w(k, 15);
        run(1, "R8 positive saturation", 0);
        for (int k = 0; k < NBR; k++) set_w(k, -15);
        run(1, "R8 negative saturation", 0);

        for (int k = 0; k < NBR; k++) set_w(k, 0);
        set_w(3, 15);
        set_w(5, -15);
        for (int i = 0; i < NC; i++) mv[i] = ((i % COLS) % 2 == 1) ? -5 : 5;
        load_model();
        run(1, "R8 cancelling sum gives plus zero", 0);

        @(negedge clk);
        start = 1'b1; load_req = 1'b1; iter_cnt = 8'd2;
        img_in = '0;
        @(negedge clk);
        start = 1'b0; load_req = 1'b0;
        @(negedge clk);
        chk("R3 load wins over start", cell_out, '0);
        chk("R3 no run after joint request", VW'(busy), VW'(0));

        repeat (3) @(negedge clk);
        chk("R4 queue drained", VW'(expq.size()), VW'(0));
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule